// File: doc/BRIEF.md
# Protection Identifier Matcher

This block decides which kinds of access a page's access identifier is allowed by comparing it against a bank of protection-identifier registers. Each register slot holds a 16-bit identifier together with a write-disable flag. A matching slot grants read and execute. It also grants write unless that slot's write-disable flag is set. The caller combines the resulting permission mask with its own access-rights decision and its own fault logic. Neither of those is part of this block.

There are two register layouts. In narrow mode each register carries one slot, in its low 32 bits. In wide mode each 64-bit register carries two slots, and they are searched in a fixed order: the low half first, then the high half, then the next register. The first slot that matches alone decides the result.

There are two bypass cases: an access identifier of zero marks a public page, and checking can be disabled. In either case every permission is granted. A separate match flag lets the caller distinguish "nothing matched" from "matched, but with reduced rights". The result is registered, so it appears one clock after the inputs.

Top module: `pid_matcher`

## Requirements
- R1: Each slot is 32 bits wide. A slot matches when its bits [16:1] equal bits [15:0] of the access identifier. Slot bits [31:17] take no part in the comparison.
- R2: A matching slot yields hit_o = 1, with read (perm_o[0]) and execute (perm_o[2]) set. Write (perm_o[1]) is set only if bit 0 (write-disable) of that slot is 0.
- R3: Registers are searched from index 0 up to index 3. Only the first matching slot determines perm_o; a later match has no effect.
- R4: With wide_i = 1, register r holds slot 2r in bits [31:0] and slot 2r+1 in bits [63:32]. They are searched in slot-index order, so the high half of register r takes precedence over the low half of register r+1.
- R5: With wide_i = 0, bits [63:32] of every register are ignored: a match there yields neither a hit nor any permission.
- R6: When checking is active and no slot matches, perm_o = 3'b000 and hit_o = 0.
- R7: When the whole access identifier is zero (public page), perm_o = 3'b111 and hit_o = 0, whatever the registers hold.
- R8: When en_i = 0, perm_o = 3'b111 and hit_o = 0, whatever the registers and the identifier hold.
- R9: perm_o and hit_o are registered. They reflect the inputs present one rising clock edge earlier. Asynchronous reset (rst_n low) forces perm_o = 3'b000 and hit_o = 0.
- R10: Identifier bits above bit 15 count only for the public-page test. An identifier whose low 16 bits are zero but whose upper bits are nonzero is checked normally, and it matches slots holding identifier 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Protection-identifier checking enable |
| wide_i | input | 1 | 1 = two slots per register, 0 = one slot per register |
| aid_i | input | AID_W (20) | Access identifier of the page |
| pid_regs_i | input | NUM_REGS*REG_W (256) | Register r occupies bits [r*64 +: 64] |
| perm_o | output | 3 | Granted mask: [0] read, [1] write, [2] execute |
| hit_o | output | 1 | A slot matched and decided perm_o |

## Verification
The hardest case to reach is a conflict where several slots carry the same identifier but different write-disable flags, with the winner decided only by search order. This matters most in wide mode, where the high half of one register competes with the low half of the next. Directed vectors place identical identifiers in adjacent slots with opposite flags, and they repeat the same pattern with the mode flipped so that the high halves drop out. A random phase draws identifiers from a set of only four values, which makes multi-slot collisions common. A behavioural search model then predicts every cycle's output.

// File: rtl/pidm_pkg.sv
package pidm_pkg;

    localparam int PERM_RD = 0;
    localparam int PERM_WR = 1;
    localparam int PERM_EX = 2;

    typedef struct packed {
        logic [2:0] perm;
        logic       hit;
    } pidm_res_t;

endpackage

// File: rtl/pidm_slot.sv
module pidm_slot #(
    parameter int SLOT_W = 32,
    parameter int ID_W   = 16,
    parameter int AID_W  = 20
) (
    input  logic [SLOT_W-1:0] slot_i,
    input  logic [AID_W-1:0]  aid_i,
    input  logic              live_i,
    output logic              hit_o,
    output logic              wd_o
);
    logic unused_bits;
    assign unused_bits = ^{slot_i[SLOT_W-1:ID_W+1], aid_i[AID_W-1:ID_W]};

    assign hit_o = live_i && (slot_i[ID_W:1] == aid_i[ID_W-1:0]);
    assign wd_o  = slot_i[0];
endmodule

// File: rtl/pidm_prio.sv
module pidm_prio #(
    parameter int N = 8
) (
    input  logic [N-1:0] req_i,
    output logic [N-1:0] gnt_o,
    output logic         any_o
);
    logic seen;

    always_comb begin
        gnt_o = '0;
        seen  = 1'b0;
        for (int k = 0; k < N; k++) begin
            if (req_i[k] && !seen) begin
                gnt_o[k] = 1'b1;
            end
            seen = seen | req_i[k];
        end
        any_o = seen;
    end

    // R3: only the first request may be granted
    always_comb begin
        p_single_grant_r3: assert ($onehot0(gnt_o));
        p_grant_iff_req_r6: assert (any_o == (gnt_o != '0));
    end
endmodule

// File: rtl/pid_matcher.sv
module pid_matcher #(
    parameter int NUM_REGS = 4,
    parameter int REG_W    = 64,
    parameter int ID_W     = 16,
    parameter int AID_W    = 20,
    parameter bit OUT_REG  = 1'b1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      en_i,
    input  logic                      wide_i,
    input  logic [AID_W-1:0]          aid_i,
    input  logic [NUM_REGS*REG_W-1:0] pid_regs_i,
    output logic [2:0]                perm_o,
    output logic                      hit_o
);
    import pidm_pkg::*;

    localparam int SLOT_W = REG_W / 2;
    localparam int NSLOT  = NUM_REGS * 2;

    function automatic logic [NSLOT-1:0] odd_mask();
        logic [NSLOT-1:0] m;
        m = '0;
        for (int k = 1; k < NSLOT; k += 2) m[k] = 1'b1;
        return m;
    endfunction
    localparam logic [NSLOT-1:0] HI_MASK = odd_mask();

    logic [NSLOT-1:0] slot_hit;
    logic [NSLOT-1:0] slot_wd;
    logic [NSLOT-1:0] gnt;
    logic             any_hit;
    pidm_res_t        res_d;
    pidm_res_t        res_q;

    // slot index 2r+h: register r, half h (0 = low, 1 = high)
    for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
        for (genvar h = 0; h < 2; h++) begin : g_half
            pidm_slot #(
                .SLOT_W (SLOT_W),
                .ID_W   (ID_W),
                .AID_W  (AID_W)
            ) u_slot (
                .slot_i (pid_regs_i[r*REG_W + h*SLOT_W +: SLOT_W]),
                .aid_i  (aid_i),
                .live_i ((h == 0) ? 1'b1 : wide_i),
                .hit_o  (slot_hit[2*r+h]),
                .wd_o   (slot_wd[2*r+h])
            );
        end
    end

    pidm_prio #(.N(NSLOT)) u_prio (
        .req_i (slot_hit),
        .gnt_o (gnt),
        .any_o (any_hit)
    );

    always_comb begin
        res_d = '0;
        if (!en_i || (aid_i == '0)) begin
            res_d.perm = 3'b111;
            res_d.hit  = 1'b0;
        end else if (any_hit) begin
            res_d.hit           = 1'b1;
            res_d.perm[PERM_RD] = 1'b1;
            res_d.perm[PERM_EX] = 1'b1;
            res_d.perm[PERM_WR] = ~|(gnt & slot_wd);
        end
    end

    if (OUT_REG) begin : g_oreg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) res_q <= '0;
            else        res_q <= res_d;
        end

        // R2: a hit always carries read and execute
        p_hit_rx_r2: assert property (@(posedge clk) disable iff (!rst_n)
            hit_o |-> (perm_o[PERM_RD] && perm_o[PERM_EX]));

        // R5: high halves never win in narrow mode
        p_narrow_hi_r5: assert property (@(posedge clk) disable iff (!rst_n)
            !wide_i |-> ((gnt & HI_MASK) == '0));

        // R7: public page opens everything one cycle later
        p_public_r7: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(aid_i == '0)) |-> (perm_o == 3'b111 && !hit_o));

        // R8: disabled checking opens everything one cycle later
        p_disabled_r8: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(!en_i)) |-> (perm_o == 3'b111 && !hit_o));

        // R9: output follows the previous cycle's evaluation
        p_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(en_i) && $past(aid_i != '0) && $past(!any_hit))
                |-> (perm_o == 3'b000 && !hit_o));
    end else begin : g_comb
        logic unused_clk;
        assign unused_clk = clk ^ rst_n;
        assign res_q = res_d;
    end

    assign perm_o = res_q.perm;
    assign hit_o  = res_q.hit;
endmodule

// File: tb/sim_pid_matcher.sv
module sim_pid_matcher;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         en_i = 1'b0;
    logic         wide_i = 1'b0;
    logic [19:0]  aid_i = '0;
    logic [255:0] regs = '0;
    logic [2:0]   perm_o;
    logic         hit_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [2:0] exp_perm;
    logic       exp_hit;
    string      exp_tag;
    bit         pending = 1'b0;

    always #10 clk = ~clk;

    pid_matcher u0 (
        .clk(clk), .rst_n(rst_n), .en_i(en_i), .wide_i(wide_i),
        .aid_i(aid_i), .pid_regs_i(regs), .perm_o(perm_o), .hit_o(hit_o)
    );

    function automatic logic [31:0] mk(input logic [15:0] id, input logic wd,
                                       input logic [14:0] junk = '0);
        return {junk, id, wd};
    endfunction

    task automatic model(output logic [2:0] p, output logic h);
        bit found = 0;
        p = 3'b000; h = 1'b0;
        if (!en_i || aid_i == 0) begin
            p = 3'b111;
            return;
        end
        for (int r = 0; r < 4; r++) begin
            for (int s = 0; s < 2; s++) begin
                logic [31:0] sl;
                if (found || (s == 1 && !wide_i)) continue;
                sl = regs[r*64 + s*32 +: 32];
                if (sl[16:1] == aid_i[15:0]) begin
                    found = 1;
                    h = 1'b1;
                    p = {1'b1, ~sl[0], 1'b1};
                end
            end
        end
    endtask

    task automatic compare(input string tag, input logic [2:0] ep, input logic eh);
        checks++;
        if (perm_o !== ep || hit_o !== eh) begin
            errors++;
            $display("FAIL %s: perm=%b hit=%b expected perm=%b hit=%b",
                     tag, perm_o, hit_o, ep, eh);
        end
    endtask

    task automatic step(input string tag, input logic en, input logic wide,
                        input logic [19:0] aid, input logic [255:0] rg);
        @(negedge clk);
        if (pending) compare(exp_tag, exp_perm, exp_hit);
        en_i = en; wide_i = wide; aid_i = aid; regs = rg;
        model(exp_perm, exp_hit);
        exp_tag = tag;
        pending = 1'b1;
    endtask

    initial begin
        #(20 * 5000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not complete");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [255:0] rg;
        repeat (3) @(negedge clk);
        compare("R9 reset", 3'b000, 1'b0);
        rst_n = 1'b1;

        // R1: narrow, register 2 matches, write allowed
        rg = '0;
        rg[128 +: 32] = mk(16'h1234, 1'b0);
        rg[0 +: 32]   = mk(16'h0111, 1'b0);
        step("R1", 1, 0, 20'h01234, rg);
        // R2: write-disable strips write
        rg[128 +: 32] = mk(16'h1234, 1'b1);
        step("R2", 1, 0, 20'h01234, rg);
        // R3: register 0 (wd) beats register 2 (no wd)
        rg = '0;
        rg[0 +: 32]   = mk(16'h00aa, 1'b1);
        rg[128 +: 32] = mk(16'h00aa, 1'b0);
        step("R3", 1, 0, 20'h000aa, rg);
        rg[0 +: 32]   = mk(16'h00aa, 1'b0);
        rg[128 +: 32] = mk(16'h00aa, 1'b1);
        step("R3 reversed", 1, 0, 20'h000aa, rg);
        // R4: high half of reg 0 beats low half of reg 1
        rg = '0;
        rg[32 +: 32] = mk(16'h0055, 1'b0);
        rg[64 +: 32] = mk(16'h0055, 1'b1);
        step("R4 hi before next", 1, 1, 20'h00055, rg);
        // R5: same registers, narrow: reg 1 low wins
        step("R5 narrow skips hi", 1, 0, 20'h00055, rg);
        // R4: low half before high half
        rg = '0;
        rg[0 +: 32]  = mk(16'h0077, 1'b1);
        rg[32 +: 32] = mk(16'h0077, 1'b0);
        step("R4 lo before hi", 1, 1, 20'h00077, rg);
        // R5: only a high half matches, narrow mode
        rg = '0;
        rg[224 +: 32] = mk(16'h0099, 1'b0);
        step("R5 hi ignored", 1, 0, 20'h00099, rg);
        step("R4 last hi slot", 1, 1, 20'h00099, rg);
        // R6: no match
        step("R6", 1, 1, 20'h00321, rg);
        // R7: public page
        step("R7", 1, 1, 20'h00000, rg);
        // R8: disabled
        step("R8", 0, 1, 20'h00321, rg);
        // R10: upper bits nonzero, low zero; junk in slot upper bits
        rg = '0;
        rg[64 +: 32] = mk(16'h0000, 1'b1, 15'h7abc);
        step("R10", 1, 0, 20'h10000, rg);
        rg[64 +: 32] = mk(16'h4321, 1'b0, 15'h1fff);
        step("R1 junk bits", 1, 0, 20'hf4321, rg);
        // R9: hold inputs, value stable
        step("R9 hold", 1, 0, 20'hf4321, rg);

        // R4: random collisions among four identifiers
        for (int n = 0; n < 300; n++) begin
            logic [255:0] rr;
            for (int s = 0; s < 8; s++)
                rr[s*32 +: 32] = mk(16'($urandom_range(1, 4)), 1'($urandom),
                                    15'($urandom));
            step("R4 random", ($urandom_range(0, 9) != 0), 1'($urandom),
                 {4'($urandom_range(0, 1)), 16'($urandom_range(0, 5))}, rr);
        end
        @(negedge clk);
        compare(exp_tag, exp_perm, exp_hit);

        // R9: asynchronous reset clears outputs
        #3 rst_n = 1'b0;
        #2 compare("R9 async reset", 3'b000, 1'b0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule